// File: doc/BRIEF.md
# Speculative Thread Register Rename Manager

This block keeps the register maps for speculative threads that start in program order. Three kinds of table are held. There is one global master map from architectural to physical registers. Each thread slot has a local map that snapshots the master when the thread is invoked. Each slot also has a pre-assign map that holds the fresh physical registers chosen for the registers the thread will write. New physical registers come from a simple FIFO free list. A busy bit per physical register stays set from the moment the mapping is published until the producing thread writes the value back.

An invocation carries two masks: the registers the thread creates (writes) and the registers it uses (reads). Table bandwidth is limited. One sequencer therefore prepares a single thread at a time, touching a fixed number of entries per cycle, while earlier threads keep executing. It first copies the master into the local map. It then pre-assigns physical registers to the created registers. Finally it publishes those registers into the master and marks them busy. Only after publication does the slot report ready. A later thread that reads a published register sees it as not ready until writeback.

A squash undoes one thread at a time, youngest first. Each created register's master entry goes back to the value held in the thread's local map, and its pre-assigned physical registers return to the free list.

Top module: `spec_rename_mgr`

## Requirements
- R1: After reset the master map sends architectural register r to physical register r, and no physical register is busy. The free list holds physical registers NUM_ARCH to NUM_PHYS-1 in ascending order, so free_count_o equals NUM_PHYS-NUM_ARCH. No slot is live or ready, and setup_busy_o is low.
- R2: An invocation is accepted only when setup_busy_o is low and the chosen slot is not live. Any other invocation is ignored and changes no table, no flag and no count. A slot is never ready without being live.
- R3: Once a slot is ready, its local map equals the master map as it stood at the moment of acceptance.
- R4: The sequencer walks the created registers in ascending register order, and each one takes the next free-list entry into the slot's pre-assign map. The destination lookup reports that register with lk_dst_valid_o high. A register that is not created reports lk_dst_valid_o low.
- R5: Publication writes each created register's pre-assigned physical register into the master map and sets that register's busy bit.
- R6: Copy, pre-assign and publish each handle COPY_W registers per cycle. setup_busy_o stays high throughout, and the slot's ready bit rises exactly 3*NUM_ARCH/COPY_W cycles after the accepting edge.
- R7: lk_src_ready_o is low when the looked-up register is in the slot's use mask and its local physical register is busy. Otherwise it is high.
- R8: A writeback clears the busy bit of the written physical register, and from the next cycle lookups report it as ready.
- R9: A squash is accepted only when setup_busy_o is low, no invocation is offered in the same cycle, and the slot is ready. For each created register it restores the master entry from the slot's local map, clears the busy bit of the pre-assigned register, and appends that register to the free-list tail in ascending register order. The slot stops being live NUM_ARCH/COPY_W cycles after acceptance. A squash of a slot that is not ready is ignored.
- R10: free_count_o falls by one for each pre-assigned register and rises by one for each register returned by a squash. It never exceeds NUM_PHYS-NUM_ARCH, and pre-assignment never draws more registers than the free list holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| invoke_i | input | 1 | Request to invoke a thread |
| invoke_slot_i | input | SW | Slot of the thread being invoked |
| create_mask_i | input | NUM_ARCH | Registers the thread writes |
| use_mask_i | input | NUM_ARCH | Registers the thread reads |
| squash_i | input | 1 | Request to squash a thread |
| squash_slot_i | input | SW | Slot to squash |
| wb_valid_i | input | 1 | Writeback of a physical register |
| wb_phys_i | input | PW | Physical register written back |
| lk_slot_i | input | SW | Slot for the lookups |
| lk_arch_i | input | AW | Architectural register looked up |
| lk_src_phys_o | output | PW | Local-map physical register |
| lk_src_ready_o | output | 1 | Source operand is ready |
| lk_dst_phys_o | output | PW | Pre-assigned physical register |
| lk_dst_valid_o | output | 1 | Register is in the create mask |
| mt_phys_o | output | PW | Master-map physical register |
| mt_busy_o | output | 1 | Busy bit of that physical register |
| setup_busy_o | output | 1 | Sequencer is setting up or squashing |
| thread_live_o | output | NUM_THR | Slot holds an invoked thread |
| thread_ready_o | output | NUM_THR | Slot setup is complete |
| free_count_o | output | CNTW | Number of free physical registers |

## Verification
The assertions take three things for granted about the inputs. No writeback targets a physical register that is sitting in the free list or being published. A thread is never invoked with more created registers than free_count_o reports. Squashes arrive youngest thread first. The stimulus keeps to this in several ways. It writes back only pre-assigned registers of ready slots. It squashes the most recently invoked slot first. It always squashes every live thread before the next pattern, so all NUM_PHYS-NUM_ARCH registers are free before a full create mask is invoked.

// File: rtl/spec_rename_pkg.sv
package spec_rename_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COPY,
    PH_PREASN,
    PH_PUBLISH,
    PH_SQUASH
  } phase_e;
endpackage

// File: rtl/spec_rename_free_fifo.sv
module spec_rename_free_fifo #(
  parameter int DEPTH = 32,
  parameter int TW    = 6,
  parameter int LANES = 4,
  parameter int BASE  = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] pop_mask_i,
  output logic [TW-1:0]    pop_data_o [LANES],
  input  logic [LANES-1:0] push_mask_i,
  input  logic [TW-1:0]    push_data_i [LANES],
  output logic [CNTW-1:0]  count_o
);
  logic [TW-1:0]   mem_q [DEPTH];
  logic [PTRW-1:0] head_q, tail_q;
  logic [CNTW-1:0] count_q;
  logic [CNTW-1:0] pop_n, push_n;
  logic [PTRW-1:0] pop_pre [LANES];
  logic [PTRW-1:0] push_pre [LANES];

  // lanes are compacted: the k-th set lane takes the k-th entry
  always_comb begin
    pop_n  = '0;
    push_n = '0;
    for (int k = 0; k < LANES; k++) begin
      pop_pre[k]    = pop_n[PTRW-1:0];
      push_pre[k]   = push_n[PTRW-1:0];
      pop_data_o[k] = mem_q[head_q + pop_pre[k]];
      pop_n  = pop_n + CNTW'(pop_mask_i[k]);
      push_n = push_n + CNTW'(push_mask_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= TW'(BASE + i);
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CNTW'(DEPTH);
    end else begin
      for (int k = 0; k < LANES; k++)
        if (push_mask_i[k]) mem_q[tail_q + push_pre[k]] <= push_data_i[k];
      head_q  <= head_q + pop_n[PTRW-1:0];
      tail_q  <= tail_q + push_n[PTRW-1:0];
      count_q <= count_q - pop_n + push_n;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/spec_rename_seq.sv
module spec_rename_seq
  import spec_rename_pkg::*;
#(
  parameter int NCHUNK = 8,
  parameter int SW     = 1,
  localparam int CHW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_setup_i,
  input  logic           start_squash_i,
  input  logic [SW-1:0]  slot_i,
  output phase_e         phase_o,
  output logic [CHW-1:0] chunk_o,
  output logic [SW-1:0]  slot_o,
  output logic           last_o
);
  phase_e         phase_q;
  logic [CHW-1:0] chunk_q;
  logic [SW-1:0]  slot_q;

  assign last_o = (chunk_q == CHW'(NCHUNK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      chunk_q <= '0;
      slot_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          chunk_q <= '0;
          if (start_setup_i) begin
            phase_q <= PH_COPY;
            slot_q  <= slot_i;
          end else if (start_squash_i) begin
            phase_q <= PH_SQUASH;
            slot_q  <= slot_i;
          end
        end
        PH_COPY: begin
          chunk_q <= last_o ? '0 : chunk_q + 1'b1;
          if (last_o) phase_q <= PH_PREASN;
        end
        PH_PREASN: begin
          chunk_q <= last_o ? '0 : chunk_q + 1'b1;
          if (last_o) phase_q <= PH_PUBLISH;
        end
        PH_PUBLISH, PH_SQUASH: begin
          chunk_q <= last_o ? '0 : chunk_q + 1'b1;
          if (last_o) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign chunk_o = chunk_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/spec_rename_mgr.sv
module spec_rename_mgr
  import spec_rename_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_THR  = 2,
  parameter int COPY_W   = 4,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int SW      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int NCHUNK  = NUM_ARCH / COPY_W,
  localparam int CHW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
  localparam int FREE_D  = NUM_PHYS - NUM_ARCH,
  localparam int CNTW    = $clog2(FREE_D + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                invoke_i,
  input  logic [SW-1:0]       invoke_slot_i,
  input  logic [NUM_ARCH-1:0] create_mask_i,
  input  logic [NUM_ARCH-1:0] use_mask_i,
  input  logic                squash_i,
  input  logic [SW-1:0]       squash_slot_i,
  input  logic                wb_valid_i,
  input  logic [PW-1:0]       wb_phys_i,
  input  logic [SW-1:0]       lk_slot_i,
  input  logic [AW-1:0]       lk_arch_i,
  output logic [PW-1:0]       lk_src_phys_o,
  output logic                lk_src_ready_o,
  output logic [PW-1:0]       lk_dst_phys_o,
  output logic                lk_dst_valid_o,
  output logic [PW-1:0]       mt_phys_o,
  output logic                mt_busy_o,
  output logic                setup_busy_o,
  output logic [NUM_THR-1:0]  thread_live_o,
  output logic [NUM_THR-1:0]  thread_ready_o,
  output logic [CNTW-1:0]     free_count_o
);
  logic [PW-1:0]       mt_q [NUM_ARCH];
  logic [PW-1:0]       lt_q [NUM_THR][NUM_ARCH];
  logic [PW-1:0]       pa_q [NUM_THR][NUM_ARCH];
  logic [NUM_ARCH-1:0] cm_q [NUM_THR];
  logic [NUM_ARCH-1:0] um_q [NUM_THR];
  logic [NUM_THR-1:0]  live_q, ready_q;
  logic [NUM_PHYS-1:0] busy_q;

  phase_e         phase;
  logic [CHW-1:0] chunk;
  logic [SW-1:0]  slot_cur;
  logic           last;

  logic [AW-1:0]     lane_arch [COPY_W];
  logic [COPY_W-1:0] lane_cm;
  logic [PW-1:0]     lane_pa [COPY_W];
  logic [PW-1:0]     lane_lt [COPY_W];
  logic [PW-1:0]     lane_mt [COPY_W];
  logic [COPY_W-1:0] pop_mask, push_mask;
  logic [PW-1:0]     pop_data [COPY_W];

  logic idle, accept_inv, accept_sq;

  assign idle       = (phase == PH_IDLE);
  assign accept_inv = invoke_i && idle && !live_q[invoke_slot_i];
  assign accept_sq  = squash_i && !invoke_i && idle && ready_q[squash_slot_i];

  spec_rename_seq #(.NCHUNK(NCHUNK), .SW(SW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_setup_i (accept_inv),
    .start_squash_i(accept_sq),
    .slot_i        (accept_inv ? invoke_slot_i : squash_slot_i),
    .phase_o       (phase),
    .chunk_o       (chunk),
    .slot_o        (slot_cur),
    .last_o        (last)
  );

  always_comb begin
    for (int k = 0; k < COPY_W; k++) begin
      lane_arch[k] = AW'(int'(chunk) * COPY_W + k);
      lane_cm[k]   = cm_q[slot_cur][lane_arch[k]];
      lane_pa[k]   = pa_q[slot_cur][lane_arch[k]];
      lane_lt[k]   = lt_q[slot_cur][lane_arch[k]];
      lane_mt[k]   = mt_q[lane_arch[k]];
    end
  end

  assign pop_mask  = (phase == PH_PREASN) ? lane_cm : '0;
  assign push_mask = (phase == PH_SQUASH) ? lane_cm : '0;

  spec_rename_free_fifo #(
    .DEPTH(FREE_D), .TW(PW), .LANES(COPY_W), .BASE(NUM_ARCH)
  ) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_mask_i (pop_mask),
    .pop_data_o (pop_data),
    .push_mask_i(push_mask),
    .push_data_i(lane_pa),
    .count_o    (free_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ARCH; r++) mt_q[r] <= PW'(r);
      for (int t = 0; t < NUM_THR; t++) begin
        for (int r = 0; r < NUM_ARCH; r++) begin
          lt_q[t][r] <= '0;
          pa_q[t][r] <= '0;
        end
        cm_q[t] <= '0;
        um_q[t] <= '0;
      end
      live_q  <= '0;
      ready_q <= '0;
    end else begin
      if (accept_inv) begin
        live_q[invoke_slot_i] <= 1'b1;
        cm_q[invoke_slot_i]   <= create_mask_i;
        um_q[invoke_slot_i]   <= use_mask_i;
      end
      case (phase)
        PH_COPY:
          for (int k = 0; k < COPY_W; k++) lt_q[slot_cur][lane_arch[k]] <= lane_mt[k];
        PH_PREASN:
          for (int k = 0; k < COPY_W; k++)
            if (lane_cm[k]) pa_q[slot_cur][lane_arch[k]] <= pop_data[k];
        PH_PUBLISH: begin
          for (int k = 0; k < COPY_W; k++)
            if (lane_cm[k]) mt_q[lane_arch[k]] <= lane_pa[k];
          if (last) ready_q[slot_cur] <= 1'b1;
        end
        PH_SQUASH: begin
          for (int k = 0; k < COPY_W; k++)
            if (lane_cm[k]) mt_q[lane_arch[k]] <= lane_lt[k];
          if (last) begin
            live_q[slot_cur]  <= 1'b0;
            ready_q[slot_cur] <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // writeback clears first; publish sets and squash clears take precedence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else begin
      if (wb_valid_i) busy_q[wb_phys_i] <= 1'b0;
      for (int k = 0; k < COPY_W; k++) begin
        if (phase == PH_PUBLISH && lane_cm[k]) busy_q[lane_pa[k]] <= 1'b1;
        if (phase == PH_SQUASH && lane_cm[k])  busy_q[lane_pa[k]] <= 1'b0;
      end
    end
  end

  logic [PW-1:0] src_phys;
  assign src_phys       = lt_q[lk_slot_i][lk_arch_i];
  assign lk_src_phys_o  = src_phys;
  assign lk_src_ready_o = !(um_q[lk_slot_i][lk_arch_i] && busy_q[src_phys]);
  assign lk_dst_phys_o  = pa_q[lk_slot_i][lk_arch_i];
  assign lk_dst_valid_o = cm_q[lk_slot_i][lk_arch_i];
  assign mt_phys_o      = mt_q[lk_arch_i];
  assign mt_busy_o      = busy_q[mt_q[lk_arch_i]];
  assign setup_busy_o   = !idle;
  assign thread_live_o  = live_q;
  assign thread_ready_o = ready_q;
endmodule

// File: rtl/spec_rename_chk.sv
module spec_rename_chk #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_THR  = 2,
  parameter int COPY_W   = 4,
  parameter int SW       = 1,
  parameter int PW       = 6,
  parameter int CNTW     = 6,
  parameter int FREE_D   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                invoke_i,
  input logic [SW-1:0]       invoke_slot_i,
  input logic                squash_i,
  input logic [SW-1:0]       squash_slot_i,
  input logic                wb_valid_i,
  input logic [PW-1:0]       wb_phys_i,
  input logic                setup_busy_o,
  input logic [NUM_THR-1:0]  thread_live_o,
  input logic [NUM_THR-1:0]  thread_ready_o,
  input logic [CNTW-1:0]     free_count_o,
  input logic [COPY_W-1:0]   pop_mask,
  input logic [NUM_PHYS-1:0] busy_q
);
  assert_ready_implies_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thread_ready_o & ~thread_live_o) == '0);

  assert_invoke_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invoke_i && !setup_busy_o && !thread_live_o[invoke_slot_i] |=> setup_busy_o);

  assert_ready_after_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((thread_ready_o & ~$past(thread_ready_o)) != '0) |-> $past(setup_busy_o));

  assert_wb_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i && !setup_busy_o |=> !busy_q[$past(wb_phys_i)]);

  assert_squash_starts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i && !invoke_i && !setup_busy_o && thread_ready_o[squash_slot_i] |=> setup_busy_o);

  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pop_mask) <= int'(free_count_o));

  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_count_o) <= FREE_D);
endmodule

bind spec_rename_mgr spec_rename_chk #(
  .NUM_PHYS(NUM_PHYS), .NUM_THR(NUM_THR), .COPY_W(COPY_W),
  .SW(SW), .PW(PW), .CNTW(CNTW), .FREE_D(FREE_D)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .invoke_i      (invoke_i),
  .invoke_slot_i (invoke_slot_i),
  .squash_i      (squash_i),
  .squash_slot_i (squash_slot_i),
  .wb_valid_i    (wb_valid_i),
  .wb_phys_i     (wb_phys_i),
  .setup_busy_o  (setup_busy_o),
  .thread_live_o (thread_live_o),
  .thread_ready_o(thread_ready_o),
  .free_count_o  (free_count_o),
  .pop_mask      (pop_mask),
  .busy_q        (busy_q)
);

// File: tb/sim_spec_rename_mgr.sv
`timescale 1ns/1ps
module sim_spec_rename_mgr;
  localparam int NA = 32, NP = 64, NT = 2, CW = 4;
  localparam int AW = 5, PW = 6, SW = 1, CNTW = 6;
  localparam int NCH = NA / CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic invoke = 1'b0, squash = 1'b0, wb_valid = 1'b0;
  logic [SW-1:0] inv_slot = '0, sq_slot = '0, lk_slot = '0;
  logic [NA-1:0] cmask = '0, umask = '0;
  logic [PW-1:0] wb_phys = '0;
  logic [AW-1:0] lk_arch = '0;
  logic [PW-1:0] src_phys, dst_phys, mt_phys;
  logic src_ready, dst_valid, mt_busy, setup_busy;
  logic [NT-1:0] live, ready;
  logic [CNTW-1:0] free_cnt;

  always #4 clk = ~clk;

  spec_rename_mgr #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_THR(NT), .COPY_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .invoke_i(invoke), .invoke_slot_i(inv_slot),
    .create_mask_i(cmask), .use_mask_i(umask), .squash_i(squash),
    .squash_slot_i(sq_slot), .wb_valid_i(wb_valid), .wb_phys_i(wb_phys),
    .lk_slot_i(lk_slot), .lk_arch_i(lk_arch), .lk_src_phys_o(src_phys),
    .lk_src_ready_o(src_ready), .lk_dst_phys_o(dst_phys), .lk_dst_valid_o(dst_valid),
    .mt_phys_o(mt_phys), .mt_busy_o(mt_busy), .setup_busy_o(setup_busy),
    .thread_live_o(live), .thread_ready_o(ready), .free_count_o(free_cnt)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  int m_mt [NA];
  bit m_busy [NP];
  int m_fifo [NP - NA];
  int m_head = 0, m_tail = 0, m_cnt = NP - NA;
  int m_lt [NT][NA];
  int m_pa [NT][NA];
  logic [NA-1:0] m_cm [NT];
  logic [NA-1:0] m_um [NT];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_invoke(input int s, input logic [NA-1:0] c, input logic [NA-1:0] u);
    m_cm[s] = c;
    m_um[s] = u;
    for (int r = 0; r < NA; r++) m_lt[s][r] = m_mt[r];
    for (int r = 0; r < NA; r++)
      if (c[r]) begin
        m_pa[s][r] = m_fifo[m_head];
        m_head = (m_head + 1) % (NP - NA);
        m_cnt--;
      end
    for (int r = 0; r < NA; r++)
      if (c[r]) begin
        m_mt[r] = m_pa[s][r];
        m_busy[m_pa[s][r]] = 1;
      end
  endtask

  task automatic model_squash(input int s);
    for (int r = 0; r < NA; r++)
      if (m_cm[s][r]) begin
        m_mt[r] = m_lt[s][r];
        m_fifo[m_tail] = m_pa[s][r];
        m_tail = (m_tail + 1) % (NP - NA);
        m_cnt++;
        m_busy[m_pa[s][r]] = 0;
      end
  endtask

  task automatic do_invoke(input int s, input logic [NA-1:0] c, input logic [NA-1:0] u,
                           input bit poke);
    int n;
    @(negedge clk);
    invoke = 1'b1; inv_slot = SW'(s); cmask = c; umask = u;
    @(posedge clk);
    #1 invoke = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (poke && n == 5) begin
        invoke = 1'b1; inv_slot = SW'(1 - s); cmask = '1;
      end else invoke = 1'b0;
      check("R6 setup_busy during setup", int'(setup_busy || ready[s]), 1);
      if (ready[s] || n > 100) break;
      n++;
    end
    invoke = 1'b0;
    check("R6 setup latency", n, 3 * NCH);
    model_invoke(s, c, u);
  endtask

  task automatic do_squash(input int s);
    int n;
    @(negedge clk);
    squash = 1'b1; sq_slot = SW'(s);
    @(posedge clk);
    #1 squash = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (!live[s] || n > 100) break;
      n++;
    end
    check("R9 squash latency", n, NCH);
    check("R9 slot not ready", int'(ready[s]), 0);
    model_squash(s);
  endtask

  task automatic check_all(input int s);
    for (int r = 0; r < NA; r++) begin
      @(negedge clk);
      lk_slot = SW'(s); lk_arch = AW'(r);
      #1;
      check("R3 local map", int'(src_phys), m_lt[s][r]);
      check("R4 dst valid", int'(dst_valid), int'(m_cm[s][r]));
      if (m_cm[s][r]) check("R4 dst phys", int'(dst_phys), m_pa[s][r]);
      check("R5 master map", int'(mt_phys), m_mt[r]);
      check("R5 master busy", int'(mt_busy), int'(m_busy[m_mt[r]]));
      check("R7 src ready", int'(src_ready), int'(!(m_um[s][r] && m_busy[m_lt[s][r]])));
    end
    check("R10 free count", int'(free_cnt), m_cnt);
  endtask

  task automatic check_master(input string tag);
    for (int r = 0; r < NA; r++) begin
      @(negedge clk);
      lk_arch = AW'(r);
      #1;
      check(tag, int'(mt_phys), m_mt[r]);
      check(tag, int'(mt_busy), int'(m_busy[m_mt[r]]));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [NA-1:0] pats [6];
    for (int r = 0; r < NA; r++) m_mt[r] = r;
    for (int p = 0; p < NP; p++) m_busy[p] = 0;
    for (int i = 0; i < NP - NA; i++) m_fifo[i] = NA + i;
    for (int t = 0; t < NT; t++) begin m_cm[t] = '0; m_um[t] = '0; end
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5555_5555;
    pats[3] = 32'hF00F_0FF0; pats[4] = 32'h8000_0001; pats[5] = 32'h1234_ABCD;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 free count", int'(free_cnt), NP - NA);
    check("R1 live", int'(live), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 setup busy", int'(setup_busy), 0);
    check_master("R1 master identity");

    // sweep of create patterns on slot 0, each squashed afterwards
    for (int p = 0; p < 6; p++) begin
      do_invoke(0, pats[p], pats[p] ^ 32'h0F0F_F0F0, 1'b0);
      check_all(0);
      do_squash(0);
      check_master("R9 master restored");
      check("R9 free count restored", int'(free_cnt), m_cnt);
    end

    // R9: squash of a slot that is not ready is ignored
    @(negedge clk);
    squash = 1'b1; sq_slot = 1'b1;
    @(negedge clk);
    squash = 1'b0;
    check("R9 ignored squash", int'(setup_busy), 0);

    // two threads: slot 1 reads registers slot 0 creates
    do_invoke(0, 32'h0000_00FF, 32'h0, 1'b1);
    check("R2 invoke during setup ignored", int'(live[1]), 0);
    do_invoke(1, 32'h0000_FF00, 32'h0000_0F0F, 1'b0);
    check_all(1);

    // R2: invoke onto a live slot is ignored
    @(negedge clk);
    invoke = 1'b1; inv_slot = 1'b0; cmask = '1; umask = '1;
    @(negedge clk);
    invoke = 1'b0;
    check("R2 live slot invoke ignored", int'(setup_busy), 0);
    check_all(0);

    // R8: writeback of slot 0's r1 and r2 results
    @(negedge clk);
    wb_valid = 1'b1; wb_phys = PW'(m_pa[0][1]);
    @(negedge clk);
    wb_phys = PW'(m_pa[0][2]);
    @(negedge clk);
    wb_valid = 1'b0;
    m_busy[m_pa[0][1]] = 0;
    m_busy[m_pa[0][2]] = 0;
    lk_slot = 1'b1; lk_arch = 5'd1;
    #1 check("R8 src ready after wb", int'(src_ready), 1);
    lk_arch = 5'd3;
    #1 check("R8 unwritten still busy", int'(src_ready), 0);
    lk_arch = 5'd4;
    #1 check("R7 unused busy reg ready", int'(src_ready), 1);
    check_all(1);

    // youngest first
    do_squash(1);
    do_squash(0);
    check_master("R9 master after double squash");
    check("R10 final free count", int'(free_cnt), NP - NA);

    // refill after reordered free list
    do_invoke(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check_all(1);
    do_squash(1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule